// File: doc/BRIEF.md
# Single-Beat Write Channel Splitter

This block takes write requests from an internal requester (an address, a data word and its byte enables) and issues each one as a single-beat AXI4 write. The address and the data go into separate queues, so the address handshake and the data handshake can complete in either order and at different times. The byte enables are stored with the data word in the data queue. When the address entry leaves on its own handshake, the strobes seen on the data channel stay the same until the data beat itself is accepted.

The block also accepts the write response and returns a one-cycle completion, carrying the response code, to the requester. A counter of outstanding writes limits how many writes can be in flight and drives the response-channel ready.

Top module: `wbs_write_splitter`

## Requirements
- R1: After reset, AWVALID, WVALID, BREADY and the completion pulse are low, and the request ready is high.
- R2: Every write is a single beat: AWLEN is 0, AWSIZE is log2 of the bus width in bytes (2 for a 32-bit bus), AWBURST is INCR (2'b01) and WLAST is always 1.
- R3: A request accepted while both queues are empty raises AWVALID and WVALID together in the next cycle, carrying that request's address, data and strobes.
- R4: The address entry is removed on the AW handshake regardless of W. The next queued address appears on the following cycle, or AWVALID drops, while the earlier W beat is still waiting. AWADDR stays stable while AWVALID is high and AWREADY is low.
- R5: WDATA and WSTRB stay unchanged while WVALID is high and WREADY is low. Each accepted W beat carries the strobes of the same request as its data, and beats leave in request order.
- R6: The request ready is low while either queue is full. A request held in that state is not taken until space frees up, and it is then issued exactly once.
- R7: BREADY is high exactly while at least one accepted write has not yet received its response.
- R8: One cycle after each B handshake, the completion output pulses for one cycle with the captured BRESP (2'b00 OKAY, 2'b10 SLVERR passed through unchanged).
- R9: The request ready is low while the number of outstanding writes equals MAX_OUTSTANDING, even when both queues are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Request is taken on this cycle if valid |
| req_addr | input | ADDR_W | Request byte address |
| req_data | input | DATA_W | Request write data |
| req_strb | input | DATA_W/8 | Request byte enables |
| done_valid | output | 1 | One-cycle completion pulse |
| done_resp | output | 2 | Response code of the completed write |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | ADDR_W | Write address |
| m_awlen | output | 8 | Burst length minus one (always 0) |
| m_awsize | output | 3 | Beat size code |
| m_awburst | output | 2 | Burst type (INCR) |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Write byte strobes |
| m_wlast | output | 1 | Last beat (always 1) |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_bresp | input | 2 | Write response code |

## Verification
On every cycle, the assertions check that a stalled W beat keeps its data and strobes, that a stalled address keeps its value, and that an idle block launches the address and data of a fresh request together. They also check that no queue is pushed while full and that the outstanding count stays within its limit. Other behaviours can only be shown by the bench's scenarios. These are that each strobe pattern is paired with its own data across back-to-back requests while the subordinate delays WREADY for several cycles after AW, that a request blocked by full queues or by the outstanding limit is issued exactly once, and that the completion codes arrive in order.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
   localparam logic [1:0] BURST_INCR  = 2'b01;
   localparam logic [7:0] SINGLE_BEAT = 8'd0;

   function automatic logic [2:0] size_code(input int unsigned bytes_per_beat);
      return 3'($clog2(bytes_per_beat));
   endfunction
endpackage

// File: rtl/wbs_queue.sv
module wbs_queue #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic             valid,
   output logic             full
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("wbs_queue: DEPTH must be at least 1");
   end
   if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_pow2
      $error("wbs_queue: DEPTH must be a power of two");
   end

   if (DEPTH == 1) begin : g_single
      logic [WIDTH-1:0] slot_q;
      logic             busy_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            busy_q <= 1'b0;
         end else if (push) begin
            busy_q <= 1'b1;
         end else if (pop) begin
            busy_q <= 1'b0;
         end
      end
      always_ff @(posedge clk) begin
         if (push) slot_q <= push_data;
      end
      assign head  = slot_q;
      assign valid = busy_q;
      assign full  = busy_q;
   end else begin : g_ring
      localparam int unsigned IDX_W = $clog2(DEPTH);
      logic [WIDTH-1:0] slots [DEPTH];
      logic [IDX_W:0]   wr_ptr, rd_ptr;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
         end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
         end
      end
      always_ff @(posedge clk) begin
         if (push) slots[wr_ptr[IDX_W-1:0]] <= push_data;
      end
      assign head  = slots[rd_ptr[IDX_W-1:0]];
      assign valid = (wr_ptr != rd_ptr);
      assign full  = (wr_ptr[IDX_W] != rd_ptr[IDX_W]) &&
                     (wr_ptr[IDX_W-1:0] == rd_ptr[IDX_W-1:0]);
   end

   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full || pop);
   assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> valid);
endmodule

// File: rtl/wbs_tracker.sv
module wbs_tracker #(
   parameter int unsigned MAX_OUTSTANDING = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       issue,
   input  logic       bvalid,
   input  logic [1:0] bresp,
   output logic       bready,
   output logic       slot_free,
   output logic       done_valid,
   output logic [1:0] done_resp
);
   if (MAX_OUTSTANDING < 1) begin : g_bad_max
      $error("wbs_tracker: MAX_OUTSTANDING must be at least 1");
   end

   localparam int unsigned CNT_W = $clog2(MAX_OUTSTANDING + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_OUTSTANDING);

   logic [CNT_W-1:0] count_q;
   logic             retire;
   logic             done_q;
   logic [1:0]       resp_q;

   assign bready    = (count_q != '0);
   assign retire    = bvalid && bready;
   assign slot_free = (count_q != CNT_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
      end else begin
         case ({issue, retire})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         resp_q <= 2'b00;
      end else begin
         done_q <= retire;
         if (retire) resp_q <= bresp;
      end
   end

   assign done_valid = done_q;
   assign done_resp  = resp_q;

   assert_within_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CNT_MAX);
   assert_no_issue_at_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q == CNT_MAX) && !retire |=> count_q == CNT_MAX || $past(retire));
   assert_resp_expected_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bvalid |-> bready);
endmodule

// File: rtl/wbs_write_splitter.sv
module wbs_write_splitter #(
   parameter int unsigned ADDR_W          = 32,
   parameter int unsigned DATA_W          = 32,
   parameter int unsigned QUEUE_DEPTH     = 4,
   parameter int unsigned MAX_OUTSTANDING = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [DATA_W-1:0]     req_data,
   input  logic [DATA_W/8-1:0]   req_strb,
   output logic                  done_valid,
   output logic [1:0]            done_resp,
   output logic                  m_awvalid,
   input  logic                  m_awready,
   output logic [ADDR_W-1:0]     m_awaddr,
   output logic [7:0]            m_awlen,
   output logic [2:0]            m_awsize,
   output logic [1:0]            m_awburst,
   output logic                  m_wvalid,
   input  logic                  m_wready,
   output logic [DATA_W-1:0]     m_wdata,
   output logic [DATA_W/8-1:0]   m_wstrb,
   output logic                  m_wlast,
   input  logic                  m_bvalid,
   output logic                  m_bready,
   input  logic [1:0]            m_bresp
);
   import wbs_pkg::*;

   localparam int unsigned STRB_W = DATA_W / 8;
   localparam int unsigned DQ_W   = DATA_W + STRB_W;

   if ((DATA_W % 8) != 0 || DATA_W < 8) begin : g_bad_width
      $error("wbs_write_splitter: DATA_W must be a positive multiple of 8");
   end
   if ((STRB_W & (STRB_W - 1)) != 0) begin : g_bad_bytes
      $error("wbs_write_splitter: DATA_W/8 must be a power of two");
   end

   logic            aq_valid, aq_full, aq_pop;
   logic            dq_valid, dq_full, dq_pop;
   logic [ADDR_W-1:0] aq_head;
   logic [DQ_W-1:0]   dq_head;
   logic            slot_free;
   logic            accept;

   assign req_ready = !aq_full && !dq_full && slot_free;
   assign accept    = req_valid && req_ready;

   assign aq_pop = aq_valid && m_awready;
   assign dq_pop = dq_valid && m_wready;

   wbs_queue #(.WIDTH(ADDR_W), .DEPTH(QUEUE_DEPTH)) u_addr_q (
      .clk(clk), .rst_n(rst_n),
      .push(accept), .push_data(req_addr),
      .pop(aq_pop), .head(aq_head), .valid(aq_valid), .full(aq_full)
   );

   // strobes ride in the same entry as the data word
   wbs_queue #(.WIDTH(DQ_W), .DEPTH(QUEUE_DEPTH)) u_data_q (
      .clk(clk), .rst_n(rst_n),
      .push(accept), .push_data({req_strb, req_data}),
      .pop(dq_pop), .head(dq_head), .valid(dq_valid), .full(dq_full)
   );

   wbs_tracker #(.MAX_OUTSTANDING(MAX_OUTSTANDING)) u_track (
      .clk(clk), .rst_n(rst_n),
      .issue(accept), .bvalid(m_bvalid), .bresp(m_bresp),
      .bready(m_bready), .slot_free(slot_free),
      .done_valid(done_valid), .done_resp(done_resp)
   );

   assign m_awvalid = aq_valid;
   assign m_awaddr  = aq_head;
   assign m_awlen   = SINGLE_BEAT;
   assign m_awsize  = size_code(STRB_W);
   assign m_awburst = BURST_INCR;

   assign m_wvalid  = dq_valid;
   assign m_wdata   = dq_head[DATA_W-1:0];
   assign m_wstrb   = dq_head[DQ_W-1:DATA_W];
   assign m_wlast   = 1'b1;

   assert_w_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      m_wvalid && !m_wready |=> m_wvalid && $stable(m_wdata) && $stable(m_wstrb));
   assert_aw_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr));
   assert_pair_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !m_awvalid && !m_wvalid |=> m_awvalid && m_wvalid);
endmodule

// File: tb/tb_wbs_write_splitter.sv
`timescale 1ns/1ps
module tb_wbs_write_splitter;
   localparam int DEPTH = 4;
   localparam int MAXO  = 8;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n;
   logic        req_valid, req_ready;
   logic [31:0] req_addr, req_data;
   logic [3:0]  req_strb;
   logic        done_valid;
   logic [1:0]  done_resp;
   logic        m_awvalid, m_awready;
   logic [31:0] m_awaddr;
   logic [7:0]  m_awlen;
   logic [2:0]  m_awsize;
   logic [1:0]  m_awburst;
   logic        m_wvalid, m_wready;
   logic [31:0] m_wdata;
   logic [3:0]  m_wstrb;
   logic        m_wlast;
   logic        m_bvalid, m_bready;
   logic [1:0]  m_bresp;

   wbs_write_splitter #(.ADDR_W(32), .DATA_W(32), .QUEUE_DEPTH(DEPTH),
                        .MAX_OUTSTANDING(MAXO)) dut (.*);

   int n_chk = 0, n_fail = 0;
   // subordinate knobs
   logic aw_en = 1'b1, b_en = 1'b1;
   int   w_delay = 0;
   // logs
   int sent_n = 0, aw_n = 0, w_n = 0, b_n = 0, done_n = 0, stab_err = 0;
   logic [31:0] s_addr [128], s_data [128], c_addr [128], c_data [128];
   logic [3:0]  s_strb [128], c_strb [128];
   logic [1:0]  d_resp [128];

   localparam logic [67:0] VEC [8] = '{
      {32'h0000_1000, 32'hA5A5_0001, 4'hF},
      {32'h0000_1004, 32'h1234_5678, 4'h1},
      {32'h0000_1008, 32'hDEAD_BEEF, 4'h2},
      {32'h0000_100C, 32'h0BAD_F00D, 4'h4},
      {32'h0000_2000, 32'hCAFE_0005, 4'h8},
      {32'h0000_2004, 32'h5555_AAAA, 4'h3},
      {32'h0000_2008, 32'hFFFF_0000, 4'hC},
      {32'h0000_200C, 32'h0000_FFFF, 4'h0}
   };

   function automatic logic [1:0] resp_for(int i);
      return (i % 3 == 2) ? 2'b10 : 2'b00;
   endfunction

   task automatic check(input bit ok, input string rid, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", rid, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk); #2;
   endtask

   task automatic send(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_data = d; req_strb = s;
      #1;
      while (!req_ready) begin @(negedge clk); #1; end
      s_addr[sent_n] = a; s_data[sent_n] = d; s_strb[sent_n] = s; sent_n++;
   endtask

   task automatic drop();
      @(negedge clk); req_valid = 1'b0; #2;
   endtask

   task automatic wait_idle(input string rid);
      int k = 0;
      while ((done_n != sent_n || m_awvalid || m_wvalid) && k < 600) begin step(); k++; end
      check(k < 600, rid, "drain", 64'(done_n), 64'(sent_n));
   endtask

   task automatic check_log(input string rid);
      check(aw_n == sent_n && w_n == sent_n, rid, "beat count", 64'(w_n), 64'(sent_n));
      for (int i = 0; i < sent_n; i++) begin
         check(c_addr[i] == s_addr[i], rid, "AWADDR", 64'(c_addr[i]), 64'(s_addr[i]));
         check({c_strb[i], c_data[i]} == {s_strb[i], s_data[i]}, rid, "WSTRB/WDATA",
               64'({c_strb[i], c_data[i]}), 64'({s_strb[i], s_data[i]}));
      end
   endtask

   // subordinate model: AW first, W after a programmable gap, B in order
   initial begin
      int gap = 0;
      bit stall_prev = 0;
      logic [35:0] prev = '0;
      m_awready = 0; m_wready = 0; m_bvalid = 0; m_bresp = 0;
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            m_awready = 0; m_wready = 0; m_bvalid = 0; stall_prev = 0; gap = 0;
         end else begin
            m_awready = aw_en;
            m_wready  = (w_n < aw_n) && (gap >= w_delay);
            m_bvalid  = b_en && (b_n < ((aw_n < w_n) ? aw_n : w_n));
            m_bresp   = resp_for(b_n);
            #1;
            if (stall_prev && (!m_wvalid || {m_wstrb, m_wdata} != prev)) stab_err++;
            stall_prev = m_wvalid && !m_wready;
            prev = {m_wstrb, m_wdata};
            if (done_valid) begin d_resp[done_n] = done_resp; done_n++; end
            if (m_awvalid && m_awready) begin c_addr[aw_n] = m_awaddr; aw_n++; end
            if (m_wvalid && m_wready) begin
               c_data[w_n] = m_wdata; c_strb[w_n] = m_wstrb; w_n++; gap = 0;
            end else if (w_n < aw_n) gap++;
            if (m_bvalid && m_bready) b_n++;
         end
      end
   end

   initial begin
      #1ms;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      rst_n = 0; req_valid = 0; req_addr = 0; req_data = 0; req_strb = 0;
      repeat (4) step();
      rst_n = 1;
      step();
      // R1 reset state
      check(!m_awvalid && !m_wvalid, "R1", "valids after reset", {m_awvalid, m_wvalid}, 0);
      check(!m_bready, "R1", "BREADY after reset", 64'(m_bready), 0);
      check(!done_valid, "R1", "done after reset", 64'(done_valid), 0);
      check(req_ready, "R1", "req_ready after reset", 64'(req_ready), 1);
      // R2 fixed beat attributes
      check(m_awlen == 8'd0 && m_awsize == 3'd2 && m_awburst == 2'b01 && m_wlast,
            "R2", "beat attributes", {m_awlen, m_awsize, m_awburst, m_wlast}, {8'd0, 3'd2, 2'b01, 1'b1});

      // R3 fresh request launches AW and W together
      aw_en = 0;
      send(32'h0000_0040, 32'h0101_0202, 4'h9);
      drop();
      check(m_awvalid && m_wvalid, "R3", "AW/W together", {m_awvalid, m_wvalid}, 2'b11);
      check(m_awaddr == 32'h40 && m_wdata == 32'h0101_0202 && m_wstrb == 4'h9, "R3", "first beat",
            {m_awaddr, m_wstrb}, {32'h40, 4'h9});
      aw_en = 1;
      wait_idle("R3");

      // R4 address leaves on its own handshake while W waits
      aw_en = 0; w_delay = 12;
      send(32'h0000_0080, 32'h1111_1111, 4'h1);
      send(32'h0000_0084, 32'h2222_2222, 4'h6);
      drop();
      aw_en = 1;
      step(); step();
      check(m_awaddr == 32'h84, "R4", "next address after AW pop", 64'(m_awaddr), 64'h84);
      check(m_wvalid && m_wdata == 32'h1111_1111 && m_wstrb == 4'h1, "R4", "W still first",
            {m_wstrb, m_wdata}, {4'h1, 32'h1111_1111});
      step();
      check(!m_awvalid && m_wvalid, "R4", "AW drained, W waiting", {m_awvalid, m_wvalid}, 2'b01);
      wait_idle("R4");
      w_delay = 0;

      // table walk: R5 strobe/data pairing, twice with different W lag
      for (int pass = 0; pass < 2; pass++) begin
         w_delay = (pass == 0) ? 0 : 3;
         step();
         for (int i = 0; i < 8; i++) send(VEC[i][67:36], VEC[i][35:4], VEC[i][3:0]);
         drop();
         wait_idle("R5");
      end
      w_delay = 0;
      check_log("R5");
      check(stab_err == 0, "R5", "W stall stability", 64'(stab_err), 0);

      // R6 full queues block requests
      aw_en = 0;
      for (int i = 0; i < DEPTH; i++) send(32'h3000 + 32'(i*4), 32'h3300_0000 + 32'(i), 4'(i+1));
      @(negedge clk);
      req_valid = 1; req_addr = 32'h3FF0; req_data = 32'h3FFF_0000; req_strb = 4'hA;
      #2;
      for (int k = 0; k < 3; k++) begin
         check(!req_ready, "R6", "ready low when full", 64'(req_ready), 0);
         step();
      end
      check(m_awaddr == 32'h3000, "R6", "head unchanged", 64'(m_awaddr), 64'h3000);
      aw_en = 1;
      #1;
      while (!req_ready) begin @(negedge clk); #1; end
      s_addr[sent_n] = 32'h3FF0; s_data[sent_n] = 32'h3FFF_0000; s_strb[sent_n] = 4'hA; sent_n++;
      drop();
      wait_idle("R6");
      check_log("R6");

      // R9 / R7 outstanding limit with responses withheld
      b_en = 0;
      for (int i = 0; i < MAXO; i++) send(32'h5000 + 32'(i*4), 32'h5500_0000 + 32'(i), 4'hF);
      drop();
      repeat (10) step();
      check(!req_ready, "R9", "ready low at limit", 64'(req_ready), 0);
      check(!m_awvalid && !m_wvalid, "R9", "queues empty at limit", {m_awvalid, m_wvalid}, 0);
      check(m_bready, "R7", "BREADY while outstanding", 64'(m_bready), 1);
      b_en = 1;
      wait_idle("R7");
      step();
      check(!m_bready, "R7", "BREADY after all responses", 64'(m_bready), 0);
      check(req_ready, "R9", "ready back after drain", 64'(req_ready), 1);

      // R8 completion count and codes
      check(done_n == sent_n, "R8", "completion count", 64'(done_n), 64'(sent_n));
      for (int i = 0; i < done_n; i++)
         check(d_resp[i] == resp_for(i), "R8", "completion code", 64'(d_resp[i]), 64'(resp_for(i)));
      check_log("R5");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule